// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral watches over software that is expected to write a key value to it at regular intervals. Software sets it up through a small register bus, with a stage-1 exponent, a stage-2 exponent, a response mode and a reset pulse length, and then sets the enable bit. From then on a prescaler divides the clock into base ticks, and a stage counter counts those ticks toward a power-of-two limit. If stage 1 runs out, the block can raise a one-cycle interrupt event and open a second stage. If the second stage also runs out, the block drives a reset pulse. Writing the key value brings the sequence back to the start of stage 1.

The response mode chooses what happens when stage 1 runs out. The block can warn first and then reset, it can reset at once, or it can only warn and rearm. After a reset pulse the block returns to idle with enable cleared, so software has to arm it again.

Top module: `wdog_timer`

## Requirements
- R1: After reset, irq_pulse and rst_out are low and every register reads 0.
- R2: Register map. Offset 0x0 holds control: bit 0 is enable, bits [2:1] are the mode and bits [5:3] are the reset length L. Offsets 0x4 and 0x8 hold the stage-1 and stage-2 exponents, which keep only data bits [3:0]. Offset 0x14 is the feed register and always reads 0. Unused read bits return 0.
- R3: With P = TICK_DIV, stage 1 ends exactly P*2^n1 clock cycles after the write that sets enable from the idle state.
- R4: In mode 0 or mode 3, the end of stage 1 gives one irq_pulse cycle and starts stage 2. rst_out then rises P*2^n2 cycles after that irq_pulse cycle.
- R5: rst_out stays high for exactly 2^L cycles. Afterwards the enable bit reads 0 and the block stays idle.
- R6: Writing 0x73 to offset 0x14 during stage 1 restarts the timing, so stage 1 ends P*2^n1 cycles after the feed write.
- R7: A 0x73 feed during stage 2 cancels the pending reset. The next irq_pulse comes P*2^n1 cycles after the feed.
- R8: A write to offset 0x14 with any value other than 0x73 (for example 0x72 or 0x173) changes no timing.
- R9: Writing 0 to the enable bit while stage 1 or stage 2 is running stops the block. No irq_pulse and no rst_out follow.
- R10: In mode 1, the end of stage 1 raises rst_out at once and gives no irq_pulse.
- R11: In mode 2, the end of stage 1 gives an irq_pulse and restarts stage 1, every P*2^n1 cycles. rst_out never rises.
- R12: irq_pulse is an event: it is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| irq_pulse | output | 1 | One-cycle warning event at the end of stage 1 |
| rst_out | output | 1 | Reset request pulse |

## Verification
The assertions check on every cycle the properties that hold at any moment. An interrupt event lasts one cycle, needs the enable bit to be set, and never coincides with the reset pulse. The reset pulse is bounded, and enable is cleared when the pulse ends. The feed register reads 0. The exact stage lengths for each exponent, the restart from a key write, the reset that a late feed cancels, the wrong key being ignored and the behaviour of each response mode depend on earlier writes. Only the bench's timed scenarios show those, by measuring the cycle distance from each write to each output event.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int          TICK_DIV = 40000,
  parameter int          ADDR_W   = 5,
  parameter int          DATA_W   = 32,
  parameter int          EXP_W    = 4,
  parameter int          LEN_W    = 3,
  parameter logic [31:0] FEED_KEY = 32'h73
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic              rst_out
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W = (1 << EXP_W);
  localparam int RST_W = (1 << LEN_W);
  localparam int CTL_W = 1 + 2 + LEN_W;
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_T1   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_T2   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(20);
  localparam logic [1:0] MODE_RST_ONLY = 2'd1;
  localparam logic [1:0] MODE_IRQ_ONLY = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ST1, S_ST2, S_RST} state_t;

  state_t           state;
  logic             en_q;
  logic [1:0]       mode_q;
  logic [LEN_W-1:0] len_q;
  logic [EXP_W-1:0] t1_q, t2_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RST_W-1:0] rcnt_q, rlim_q;
  logic             irq_q;

  wire wr_any  = bus_sel & bus_wr;
  wire wr_ctl  = wr_any & (bus_addr == A_CTL);
  wire wr_t1   = wr_any & (bus_addr == A_T1);
  wire wr_t2   = wr_any & (bus_addr == A_T2);
  wire feed_ok = wr_any & (bus_addr == A_FEED) & (bus_wdata == DATA_W'(FEED_KEY));

  wire             tick = (pre_q == PRE_W'(TICK_DIV - 1));
  wire [CNT_W-1:0] lim  = CNT_W'(1) << ((state == S_ST2) ? t2_q : t1_q);
  wire             hit  = tick & (cnt_q == lim - CNT_W'(1));
  wire             rdone = (rcnt_q == rlim_q - RST_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      en_q   <= 1'b0;
      mode_q <= '0;
      len_q  <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
      rcnt_q <= '0;
      rlim_q <= RST_W'(1);
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_ctl) {len_q, mode_q, en_q} <= bus_wdata[CTL_W-1:0];
      if (wr_t1)  t1_q <= bus_wdata[EXP_W-1:0];
      if (wr_t2)  t2_q <= bus_wdata[EXP_W-1:0];
      case (state)
        S_IDLE: begin
          if (wr_ctl && bus_wdata[0]) begin
            state <= S_ST1;
            pre_q <= '0;
            cnt_q <= '0;
          end
        end
        S_ST1, S_ST2: begin
          if (wr_ctl && !bus_wdata[0]) begin
            state <= S_IDLE;
          end else if (feed_ok) begin
            state <= S_ST1;
            pre_q <= '0;
            cnt_q <= '0;
          end else if (hit) begin
            pre_q <= '0;
            cnt_q <= '0;
            if (state == S_ST2 || mode_q == MODE_RST_ONLY) begin
              state  <= S_RST;
              rcnt_q <= '0;
              rlim_q <= RST_W'(1) << len_q;
            end else begin
              irq_q <= 1'b1;
              if (mode_q != MODE_IRQ_ONLY) state <= S_ST2;
            end
          end else begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
            if (tick) cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_RST: begin
          if (rdone) begin
            state <= S_IDLE;
            en_q  <= 1'b0;
          end else begin
            rcnt_q <= rcnt_q + RST_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign irq_pulse = irq_q;
  assign rst_out   = (state == S_RST);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:   bus_rdata[CTL_W-1:0] = {len_q, mode_q, en_q};
      A_T1:    bus_rdata[EXP_W-1:0] = t1_q;
      A_T2:    bus_rdata[EXP_W-1:0] = t2_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module wdog_timer_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_pulse,
  input logic              rst_out,
  input logic              en_q,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  logic [8:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (rst_out) run_q <= run_q + 9'd1;
    else run_q <= '0;
  end

  assert_irq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pulse) |-> $past(en_q));
  assert_no_irq_in_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> !irq_pulse);
  assert_en_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> !en_q);
  assert_rst_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out |-> run_q < 9'd128);
  assert_feed_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(20)) |-> (bus_rdata == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .rst_out(rst_out),
  .en_q(en_q), .bus_addr(bus_addr), .bus_rdata(bus_rdata));

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_pulse, rst_out;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int irq_n = 0, irq_at = 0, irq_run = 0, irq_max = 0;
  int rst_n_cnt = 0, rst_at = 0, rst_run = 0, rst_len = 0;
  logic rst_prev = 1'b0;

  wdog_timer #(.TICK_DIV(TICK)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .rst_out(rst_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (irq_pulse) begin
      irq_n++; irq_at = cyc; irq_run++;
      if (irq_run > irq_max) irq_max = irq_run;
    end else irq_run = 0;
    if (rst_out && !rst_prev) begin rst_n_cnt++; rst_at = cyc; rst_run = 0; end
    if (rst_out) rst_run++;
    if (!rst_out && rst_prev) rst_len = rst_run;
    rst_prev = rst_out;
  end

  function automatic int f_stage(int n); return TICK * (1 << n); endfunction
  function automatic int f_pulse(int l); return 1 << l; endfunction

  task automatic chk(int act, int exp, string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output int t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; t = cyc;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1; d = int'(bus_rdata);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(int l, int m, int e);
    return 32'((l << 3) | (m << 1) | e);
  endfunction

  task automatic two_stage(int n1, int n2, int l, int m, string tag);
    int t, t0, i0, r0, d;
    wr(5'h04, 32'(n1), t);
    wr(5'h08, 32'(n2), t);
    i0 = irq_n; r0 = rst_n_cnt;
    wr(5'h00, ctl(l, m, 1), t0);
    idle(f_stage(n1) + f_stage(n2) + f_pulse(l) + 6);
    chk(irq_n - i0, 1, {tag, " R4 irq count"});
    chk(irq_at - t0, f_stage(n1), {tag, " R3 stage1 length"});
    chk(rst_n_cnt - r0, 1, {tag, " R4 reset count"});
    chk(rst_at - irq_at, f_stage(n2), {tag, " R4 stage2 length"});
    chk(rst_len, f_pulse(l), {tag, " R5 pulse length"});
    rd(5'h00, d);
    chk(d & 1, 0, {tag, " R5 enable cleared"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t, t0, tf, d, i0, r0;
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R1
    chk(int'(irq_pulse), 0, "R1 irq");
    chk(int'(rst_out), 0, "R1 rst");
    rd(5'h00, d); chk(d, 0, "R1 ctl");
    rd(5'h04, d); chk(d, 0, "R1 t1");
    rd(5'h08, d); chk(d, 0, "R1 t2");

    // R2
    wr(5'h00, ctl(5, 2, 0) | 32'hFFFF_FF00, t);
    rd(5'h00, d); chk(d, 32'h2C, "R2 ctl readback");
    wr(5'h04, 32'hFFFF_FFF5, t);
    rd(5'h04, d); chk(d, 5, "R2 t1 readback");
    wr(5'h08, 32'h0000_001A, t);
    rd(5'h08, d); chk(d, 10, "R2 t2 readback");
    wr(5'h14, 32'h73, t);
    rd(5'h14, d); chk(d, 0, "R2 feed reads zero");
    rd(5'h0C, d); chk(d, 0, "R2 unused offset");
    wr(5'h00, 0, t);

    // R3 R4 R5 directed corners
    two_stage(0, 0, 0, 0, "min");
    two_stage(3, 2, 3, 3, "mode3");

    // R6 feed in stage 1
    wr(5'h04, 3, t); wr(5'h08, 3, t);
    i0 = irq_n;
    wr(5'h00, ctl(0, 0, 1), t0);
    idle(10);
    wr(5'h14, 32'h73, tf);
    idle(f_stage(3) + 2);
    chk(irq_n - i0, 1, "R6 irq count");
    chk(irq_at - tf, f_stage(3), "R6 restart from feed");
    wr(5'h00, 0, t);

    // R7 feed in stage 2
    i0 = irq_n; r0 = rst_n_cnt;
    wr(5'h00, ctl(0, 0, 1), t0);
    idle(f_stage(3) + 5);
    wr(5'h14, 32'h73, tf);
    idle(f_stage(3) + 2);
    chk(irq_n - i0, 2, "R7 irq count");
    chk(irq_at - tf, f_stage(3), "R7 restart after stage2 feed");
    chk(rst_n_cnt - r0, 0, "R7 reset cancelled");
    wr(5'h00, 0, t);

    // R8 wrong keys
    i0 = irq_n;
    wr(5'h00, ctl(0, 0, 1), t0);
    idle(5);
    wr(5'h14, 32'h72, t);
    wr(5'h14, 32'h173, t);
    idle(f_stage(3));
    chk(irq_n - i0, 1, "R8 irq count");
    chk(irq_at - t0, f_stage(3), "R8 timing unchanged");
    wr(5'h00, 0, t);

    // R9 disable
    i0 = irq_n; r0 = rst_n_cnt;
    wr(5'h00, ctl(0, 0, 1), t0);
    idle(8);
    wr(5'h00, ctl(0, 0, 0), t);
    idle(3 * f_stage(3));
    chk(irq_n - i0, 0, "R9 no irq");
    chk(rst_n_cnt - r0, 0, "R9 no reset");

    // R10 mode 1
    wr(5'h04, 2, t);
    i0 = irq_n; r0 = rst_n_cnt;
    wr(5'h00, ctl(2, 1, 1), t0);
    idle(f_stage(2) + f_pulse(2) + 4);
    chk(irq_n - i0, 0, "R10 no irq");
    chk(rst_n_cnt - r0, 1, "R10 reset count");
    chk(rst_at - t0, f_stage(2), "R10 reset timing");
    chk(rst_len, f_pulse(2), "R10 pulse length");

    // R11 mode 2
    i0 = irq_n; r0 = rst_n_cnt;
    wr(5'h00, ctl(0, 2, 1), t0);
    idle(2 * f_stage(2) + 2);
    chk(irq_n - i0, 2, "R11 irq count");
    chk(irq_at - t0, 2 * f_stage(2), "R11 second irq timing");
    chk(rst_n_cnt - r0, 0, "R11 no reset");
    wr(5'h00, 0, t);

    // random two-stage runs
    for (int k = 0; k < 8; k++) begin
      int n1, n2, l, m;
      n1 = int'($urandom_range(0, 4));
      n2 = int'($urandom_range(0, 4));
      l  = int'($urandom_range(0, 7));
      m  = ($urandom_range(0, 1) != 0) ? 3 : 0;
      two_stage(n1, n2, l, m, "rand");
    end

    // R12
    chk(irq_max, 1, "R12 irq width");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule